// File: doc/BRIEF.md
# Prioritized Interrupt Vector Tracker

This block keeps the interrupt state for one processor across 256 vector numbers. It holds three bit vectors, one bit per vector number: a request-waiting set, a being-serviced set and an enable mask. An interrupt source posts a vector number on the raise port. The processor side sees a single pending flag and the number of the vector it should take next. When it takes that vector it returns the number on the acknowledge port. When the handler finishes it pulses an end-of-interrupt strobe.

Priority is purely numeric: a larger vector number always wins. A waiting vector is only offered to the processor when its number lies strictly above every vector currently in service, so a handler can only be preempted by a more important vector. A plain 32-bit register port lets software read all three sets slice by slice and rewrite the enable mask. The low four address bits are ignored.

Top module: `ivt_tracker`

## Requirements
- R1: After reset the waiting and in-service sets are all zeros, the enable mask is all ones, and `irq_pend` is low.
- R2: Vector v lives at bit v%32 of slice v/32 in each set. Slice k of the in-service set reads at 0x100+16k, of the waiting set at 0x200+16k, and of the enable mask at 0x480+16k, for k in 0..7.
- R3: A raise of vector v sets its waiting bit at the next clock edge only if enable bit v is 1. A raise with enable bit v at 0 leaves the waiting set unchanged. A raise of a vector that is already waiting changes nothing. The raise sees the enable value from before any same-cycle register write.
- R4: `irq_vec` is the highest-numbered waiting vector whenever `irq_pend` is high.
- R5: `irq_pend` is high exactly when some vector is waiting and the highest waiting number is strictly greater than the highest in-service number. An empty in-service set counts as -1.
- R6: An acknowledge of a waiting vector v clears its waiting bit and sets its in-service bit at the next clock edge.
- R7: An acknowledge of a vector that is not waiting changes neither set.
- R8: An end-of-interrupt strobe clears only the highest-numbered in-service bit. With the in-service set empty it has no effect.
- R9: Writes to enable slices replace that slice. Writes to in-service or waiting slices are dropped. Reads outside the three slice ranges return zero.
- R10: A raise and an acknowledge of the same waiting vector in one cycle leave it both in service and waiting again. The acknowledge applies first and the raise then re-posts the vector.
- R11: An end-of-interrupt and an acknowledge in the same cycle first retire the previous highest in-service vector and then mark the acknowledged vector in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raise_vld | input | 1 | Raise strobe |
| raise_vec | input | 8 | Vector number being raised |
| ack_vld | input | 1 | Acknowledge strobe from the processor |
| ack_vec | input | 8 | Vector number being acknowledged |
| eoi | input | 1 | End-of-interrupt strobe |
| irq_pend | output | 1 | A vector is offered to the processor |
| irq_vec | output | 8 | Number of the offered vector |
| reg_addr | input | 12 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |

## Verification
On every cycle the assertions check the following. The reset contents are correct. A masked raise cannot create a waiting bit. An acknowledge either moves a waiting vector into service or leaves an idle one out of it. An end-of-interrupt removes exactly one in-service bit. An offered vector is waiting and has no in-service vector at or above it.

The bench scenarios show the rest. They confirm which vector wins among several waiting ones and how slices map onto register addresses. They check that writes to read-only slices are dropped. They also cover the ordering rules for same-cycle raise/acknowledge and acknowledge/end-of-interrupt, which the assertions leave open.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    // Slice layout of the register port: bases and stride in bytes.
    localparam int SVC_BASE     = 'h100;
    localparam int PEND_BASE    = 'h200;
    localparam int EN_BASE      = 'h480;
    localparam int SLICE_STRIDE = 16;
    localparam int STRIDE_SHIFT = 4;

    typedef enum logic [1:0] {
        BANK_NONE,
        BANK_SVC,
        BANK_PEND,
        BANK_EN
    } bank_e;
endpackage

// File: rtl/ivt_prio_enc.sv
module ivt_prio_enc #(
    parameter int N  = 256,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          vld,
    output logic [IW-1:0] idx
);
    // The last set bit seen on an upward walk is the highest one.
    always_comb begin
        vld = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                vld = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/ivt_regport.sv
module ivt_regport
    import ivt_pkg::*;
#(
    parameter int NUM_VEC = 256,
    parameter int SLICE_W = 32,
    parameter int ADDR_W  = 12,
    localparam int NUM_SLICES = NUM_VEC / SLICE_W,
    localparam int SLC_W      = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr,
    input  logic [NUM_VEC-1:0] svc,
    input  logic [NUM_VEC-1:0] pend,
    input  logic [NUM_VEC-1:0] en,
    output logic [SLICE_W-1:0] rdata,
    output logic               en_wr,
    output logic [SLC_W-1:0]   en_slice
);
    localparam int SPAN = NUM_SLICES * SLICE_STRIDE;

    bank_e            bank;
    logic [ADDR_W-1:0] off;
    logic [SLC_W-1:0]  slice;

    logic [SLICE_W-1:0] svc_s  [NUM_SLICES];
    logic [SLICE_W-1:0] pend_s [NUM_SLICES];
    logic [SLICE_W-1:0] en_s   [NUM_SLICES];

    for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
        assign svc_s[k]  = svc[k*SLICE_W +: SLICE_W];
        assign pend_s[k] = pend[k*SLICE_W +: SLICE_W];
        assign en_s[k]   = en[k*SLICE_W +: SLICE_W];
    end

    always_comb begin
        bank = BANK_NONE;
        off  = '0;
        if (addr >= ADDR_W'(SVC_BASE) && addr < ADDR_W'(SVC_BASE + SPAN)) begin
            bank = BANK_SVC;
            off  = addr - ADDR_W'(SVC_BASE);
        end else if (addr >= ADDR_W'(PEND_BASE) && addr < ADDR_W'(PEND_BASE + SPAN)) begin
            bank = BANK_PEND;
            off  = addr - ADDR_W'(PEND_BASE);
        end else if (addr >= ADDR_W'(EN_BASE) && addr < ADDR_W'(EN_BASE + SPAN)) begin
            bank = BANK_EN;
            off  = addr - ADDR_W'(EN_BASE);
        end
        slice = SLC_W'(off >> STRIDE_SHIFT);
    end

    always_comb begin
        unique case (bank)
            BANK_SVC:  rdata = svc_s[slice];
            BANK_PEND: rdata = pend_s[slice];
            BANK_EN:   rdata = en_s[slice];
            default:   rdata = '0;
        endcase
    end

    // Only the enable mask is writable; other banks drop writes.
    assign en_wr    = wr && (bank == BANK_EN);
    assign en_slice = slice;
endmodule

// File: rtl/ivt_state.sv
module ivt_state #(
    parameter int NUM_VEC = 256,
    parameter int SLICE_W = 32,
    localparam int VEC_W      = $clog2(NUM_VEC),
    localparam int NUM_SLICES = NUM_VEC / SLICE_W,
    localparam int SLC_W      = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               raise_vld,
    input  logic [VEC_W-1:0]   raise_vec,
    input  logic               ack_vld,
    input  logic [VEC_W-1:0]   ack_vec,
    input  logic               eoi,
    input  logic               svc_vld,
    input  logic [VEC_W-1:0]   svc_top,
    input  logic               en_wr,
    input  logic [SLC_W-1:0]   en_slice,
    input  logic [SLICE_W-1:0] en_wdata,
    output logic [NUM_VEC-1:0] pend_q,
    output logic [NUM_VEC-1:0] svc_q,
    output logic [NUM_VEC-1:0] en_q
);
    logic               ack_hit;
    logic [NUM_VEC-1:0] ack_mask, raise_mask, eoi_mask;
    logic [NUM_VEC-1:0] pend_d, svc_d;

    always_comb begin
        ack_hit    = ack_vld && pend_q[ack_vec];
        ack_mask   = ack_hit ? (NUM_VEC'(1) << ack_vec) : '0;
        raise_mask = (raise_vld && en_q[raise_vec]) ? (NUM_VEC'(1) << raise_vec) : '0;
        eoi_mask   = (eoi && svc_vld) ? (NUM_VEC'(1) << svc_top) : '0;
        // Acknowledge first, then raise may re-post the same vector.
        pend_d     = (pend_q & ~ack_mask) | raise_mask;
        // Retire the old top first, then mark the acknowledged vector.
        svc_d      = (svc_q & ~eoi_mask) | ack_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            svc_q  <= '0;
        end else begin
            pend_q <= pend_d;
            svc_q  <= svc_d;
        end
    end

    for (genvar k = 0; k < NUM_SLICES; k++) begin : g_en
        always_ff @(posedge clk) begin
            if (rst)
                en_q[k*SLICE_W +: SLICE_W] <= '1;
            else if (en_wr && en_slice == SLC_W'(k))
                en_q[k*SLICE_W +: SLICE_W] <= en_wdata;
        end
    end
endmodule

// File: rtl/ivt_tracker.sv
module ivt_tracker #(
    parameter int NUM_VEC = 256,
    parameter int SLICE_W = 32,
    parameter int ADDR_W  = 12,
    localparam int VEC_W      = $clog2(NUM_VEC),
    localparam int NUM_SLICES = NUM_VEC / SLICE_W,
    localparam int SLC_W      = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               raise_vld,
    input  logic [VEC_W-1:0]   raise_vec,
    input  logic               ack_vld,
    input  logic [VEC_W-1:0]   ack_vec,
    input  logic               eoi,
    output logic               irq_pend,
    output logic [VEC_W-1:0]   irq_vec,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [SLICE_W-1:0] reg_wdata,
    output logic [SLICE_W-1:0] reg_rdata
);
    logic [NUM_VEC-1:0] pend_vec, svc_vec, en_vec;
    logic               pend_any, svc_any;
    logic [VEC_W-1:0]   pend_top, svc_top;
    logic               en_wr;
    logic [SLC_W-1:0]   en_slice;

    ivt_prio_enc #(.N(NUM_VEC), .IW(VEC_W)) u_pend_enc (
        .req(pend_vec), .vld(pend_any), .idx(pend_top)
    );

    ivt_prio_enc #(.N(NUM_VEC), .IW(VEC_W)) u_svc_enc (
        .req(svc_vec), .vld(svc_any), .idx(svc_top)
    );

    ivt_state #(.NUM_VEC(NUM_VEC), .SLICE_W(SLICE_W)) u_state (
        .clk(clk), .rst(rst),
        .raise_vld(raise_vld), .raise_vec(raise_vec),
        .ack_vld(ack_vld), .ack_vec(ack_vec),
        .eoi(eoi), .svc_vld(svc_any), .svc_top(svc_top),
        .en_wr(en_wr), .en_slice(en_slice), .en_wdata(reg_wdata),
        .pend_q(pend_vec), .svc_q(svc_vec), .en_q(en_vec)
    );

    ivt_regport #(.NUM_VEC(NUM_VEC), .SLICE_W(SLICE_W), .ADDR_W(ADDR_W)) u_regs (
        .addr(reg_addr), .wr(reg_wr),
        .svc(svc_vec), .pend(pend_vec), .en(en_vec),
        .rdata(reg_rdata), .en_wr(en_wr), .en_slice(en_slice)
    );

    assign irq_pend = pend_any && (!svc_any || (pend_top > svc_top));
    assign irq_vec  = pend_top;
endmodule

// File: rtl/ivt_tracker_chk.sv
module ivt_tracker_chk #(
    parameter int NUM_VEC = 256,
    parameter int VEC_W   = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               raise_vld,
    input logic [VEC_W-1:0]   raise_vec,
    input logic               ack_vld,
    input logic [VEC_W-1:0]   ack_vec,
    input logic               eoi,
    input logic               irq_pend,
    input logic [VEC_W-1:0]   irq_vec,
    input logic [NUM_VEC-1:0] pend_q,
    input logic [NUM_VEC-1:0] svc_q,
    input logic [NUM_VEC-1:0] en_q
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (pend_q == '0 && svc_q == '0 && en_q == '1));

    // R3
    masked_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (raise_vld && !en_q[raise_vec] && !pend_q[raise_vec]) |=> !pend_q[$past(raise_vec)]);

    // R5
    irq_order_chk: assert property (@(posedge clk) disable iff (rst)
        irq_pend |-> (pend_q[irq_vec] && ((svc_q >> irq_vec) == '0)));

    // R6
    ack_move_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_vld && pend_q[ack_vec]) |=> svc_q[$past(ack_vec)]);

    // R7
    ack_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_vld && !pend_q[ack_vec] && !svc_q[ack_vec]) |=> !svc_q[$past(ack_vec)]);

    // R8
    eoi_one_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi && !ack_vld && svc_q != '0) |=> ($countones(svc_q) + 1 == $countones($past(svc_q))));

    // R8
    eoi_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi && !ack_vld && svc_q == '0) |=> (svc_q == '0));
endmodule

bind ivt_tracker ivt_tracker_chk #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst(rst),
    .raise_vld(raise_vld), .raise_vec(raise_vec),
    .ack_vld(ack_vld), .ack_vec(ack_vec), .eoi(eoi),
    .irq_pend(irq_pend), .irq_vec(irq_vec),
    .pend_q(pend_vec), .svc_q(svc_vec), .en_q(en_vec)
);

// File: tb/ivt_tracker_bench.sv
module ivt_tracker_bench;
    localparam int NV = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        raise_vld = 1'b0;
    logic [7:0]  raise_vec = '0;
    logic        ack_vld = 1'b0;
    logic [7:0]  ack_vec = '0;
    logic        eoi = 1'b0;
    logic        irq_pend;
    logic [7:0]  irq_vec;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    logic [NV-1:0] m_pend = '0;
    logic [NV-1:0] m_svc  = '0;
    logic [NV-1:0] m_en   = '1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ivt_tracker u_ivt_tracker (
        .clk(clk), .rst(rst),
        .raise_vld(raise_vld), .raise_vec(raise_vec),
        .ack_vld(ack_vld), .ack_vec(ack_vec), .eoi(eoi),
        .irq_pend(irq_pend), .irq_vec(irq_vec),
        .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic int top_bit(input logic [NV-1:0] v);
        int r = -1;
        for (int i = 0; i < NV; i++) if (v[i]) r = i;
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // One clock with the given stimulus; the model follows the requirements.
    task automatic step(input bit r_on, input int rv, input bit a_on, input int av,
                        input bit e_on, input bit w_on, input int wa, input logic [31:0] wd);
        logic [NV-1:0] np, ns, ne;
        bit hit;
        int t;
        @(negedge clk);
        raise_vld = r_on; raise_vec = rv[7:0];
        ack_vld = a_on;   ack_vec = av[7:0];
        eoi = e_on;
        reg_wr = w_on; reg_addr = wa[11:0]; reg_wdata = wd;
        ne = m_en;
        if (w_on && wa >= 'h480 && wa < 'h500) ne[((wa - 'h480) >> 4) * 32 +: 32] = wd;
        hit = a_on && m_pend[av];
        np = m_pend;
        if (hit) np[av] = 1'b0;
        if (r_on && m_en[rv]) np[rv] = 1'b1;
        ns = m_svc;
        t = top_bit(m_svc);
        if (e_on && t >= 0) ns[t] = 1'b0;
        if (hit) ns[av] = 1'b1;
        @(posedge clk);
        #1;
        m_pend = np; m_svc = ns; m_en = ne;
        raise_vld = 1'b0; ack_vld = 1'b0; eoi = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic idle_raise(input int v); step(1, v, 0, 0, 0, 0, 0, 0); endtask
    task automatic idle_ack(input int v);   step(0, 0, 1, v, 0, 0, 0, 0); endtask
    task automatic idle_eoi();              step(0, 0, 0, 0, 1, 0, 0, 0); endtask

    task automatic read(input int a, output logic [31:0] d);
        reg_addr = a[11:0];
        #1;
        d = reg_rdata;
    endtask

    // Compare every slice of every set plus the processor-side outputs.
    task automatic compare_all(input string tag);
        logic [31:0] d;
        int hp, hs;
        for (int k = 0; k < 8; k++) begin
            read('h100 + 16 * k, d); chk({tag, " svc slice"},  d, m_svc[k*32 +: 32]);
            read('h200 + 16 * k, d); chk({tag, " pend slice"}, d, m_pend[k*32 +: 32]);
            read('h480 + 16 * k, d); chk({tag, " en slice"},   d, m_en[k*32 +: 32]);
        end
        hp = top_bit(m_pend);
        hs = top_bit(m_svc);
        chk({tag, " irq_pend"}, {31'd0, irq_pend}, {31'd0, (hp >= 0 && hp > hs)});
        if (hp >= 0 && hp > hs) chk({tag, " irq_vec"}, {24'd0, irq_vec}, hp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int other;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset contents, R2 slice addressing
        compare_all("R1");

        // R2 R4 R5 R6 R8 sweep over every vector with a second competitor
        for (int v = 0; v < NV; v++) begin
            other = v ^ 'hA5;
            idle_raise(v);      compare_all("R2");
            idle_raise(other);  compare_all("R4");
            idle_ack(v > other ? v : other);   compare_all("R6");
            idle_ack(v > other ? other : v);   compare_all("R5");
            idle_eoi();         compare_all("R8");
            idle_eoi();         compare_all("R8");
        end

        // R3 masked raise and merge of a repeated raise
        step(0, 0, 0, 0, 0, 1, 'h490, 32'h0000_0000);
        compare_all("R9");
        idle_raise(40);     compare_all("R3");
        step(0, 0, 0, 0, 0, 1, 'h490, 32'hFFFF_FFFF);
        idle_raise(40);     compare_all("R3");
        idle_raise(40);     compare_all("R3");
        // R3 raise sees the old enable when a write lands in the same cycle
        step(1, 41, 0, 0, 0, 1, 'h490, 32'h0000_0000);
        compare_all("R3");
        step(0, 0, 0, 0, 0, 1, 'h490, 32'hFFFF_FFFF);

        // R7 acknowledge of a vector that is not waiting
        idle_ack(200);      compare_all("R7");
        idle_ack(40);       compare_all("R6");
        idle_ack(41);       compare_all("R6");

        // R5 strict ordering against in-service vectors
        idle_raise(30);     compare_all("R5");
        idle_raise(41);     compare_all("R5");
        idle_raise(42);     compare_all("R5");
        idle_ack(42);       compare_all("R6");
        idle_eoi();         compare_all("R8");
        idle_eoi();         compare_all("R8");
        idle_eoi();         compare_all("R8");

        // R9 writes to read-only banks and unmapped reads
        step(0, 0, 0, 0, 0, 1, 'h200, 32'hFFFF_FFFF); compare_all("R9");
        step(0, 0, 0, 0, 0, 1, 'h170, 32'hFFFF_FFFF); compare_all("R9");
        step(0, 0, 0, 0, 0, 1, 'h4F0, 32'h1234_5678); compare_all("R9");
        read('h180, d); chk("R9 unmapped", d, 32'h0);
        read('h500, d); chk("R9 unmapped", d, 32'h0);
        read('h0F0, d); chk("R9 unmapped", d, 32'h0);

        // R10 raise and acknowledge of the same waiting vector
        step(1, 30, 1, 30, 0, 0, 0, 0);
        compare_all("R10");
        chk("R10 svc bit",  {31'd0, m_svc[30]},  32'd1);
        chk("R10 pend bit", {31'd0, m_pend[30]}, 32'd1);

        // R11 end-of-interrupt together with acknowledge
        step(0, 0, 1, 30, 1, 0, 0, 0);
        compare_all("R11");
        idle_raise(10);
        idle_ack(10);
        idle_raise(20);
        step(0, 0, 1, 20, 1, 0, 0, 0);
        compare_all("R11");
        idle_eoi();         compare_all("R8");
        idle_eoi();         compare_all("R8");

        finish_run();
    end
endmodule